// File: doc/BRIEF.md
# Four-Stage Watchdog with Unlock Key

This block is a watchdog timer that escalates through four stages in a fixed order. A prescaler divides the block clock into watchdog ticks. Each stage counts ticks up to its own 32-bit limit. When the limit is reached, the stage carries out its configured action and hands over to the next stage. Stage 3 hands back to stage 0. The four possible actions are to do nothing, to raise an interrupt, to pulse a CPU reset, or to pulse a system reset. Each reset pulse has its own 3-bit length code.

Software reaches the block through a simple register port: a write strobe, an address, write data and combinational read data. A write of any value to the restart register puts the sequence back at the start of stage 0. The configuration registers are guarded by a 32-bit key register. Writes to them take effect only while the key register holds 0x50D83AA1, which is also its reset value. Writing any other value into the key locks the configuration. Writing the unlock value back opens it again.

Top module: `wdog_stages`

## Requirements
- R1: After reset the registers read as follows. Address 0 reads 0x1200: run bit 0, all actions 0, both length codes 1. Address 1 (prescaler) reads 1. Addresses 2..5 (stage limits 0..3) read 26000000, 134217727, 1048575 and 1048575. Address 7 (key) reads 0x50D83AA1. Addresses 8 and 9 read 0. The outputs irq, cpu_rst and sys_rst are low.
- R2: While the key register differs from 0x50D83AA1, writes to addresses 0, 1, 2..5 and 8 leave those registers unchanged. Writes to the key register (address 7) always take effect.
- R3: While the run bit is 0, the watchdog does not count and takes no action. The stage is held at 0 with zero counts.
- R4: The prescaler P is 16 bits wide; a value of 0 acts as 1. The current stage expires on the P×T-th rising edge during which the run bit is set, where T is that stage's limit. The interrupt raised by an expiry is visible after that edge.
- R5: Stages run in the order 0, 1, 2, 3, 0. An expiry clears the tick count and the prescale count. A stage whose action is 0 expires without any visible effect.
- R6: An action code of 1 sets the raw interrupt bit, 2 starts a cpu_rst pulse and 3 starts a sys_rst pulse. Each action takes effect on the edge at which its stage expires.
- R7: Length codes 0..7 give pulses of 8, 16, 24, 32, 40, 64, 128 and 256 clock cycles. A pulse starts on the edge after the load. An expiry that occurs during a pulse restarts that pulse.
- R8: A write of any data to address 6 restarts the sequence at stage 0 with zero counts. This write is honoured even while the configuration is locked.
- R9: The irq output is the raw interrupt bit AND the enable bit (address 8, bit 0). Writing data with bit 0 set to address 9 clears the raw bit, even while locked. Reading address 9 returns the raw bit. A set and a clear on the same edge leave the bit set.
- R10: Address 0 has this layout: bit 0 is the run bit; bits [2s+2:2s+1] hold the action of stage s; bits [11:9] hold the CPU pulse length code; bits [14:12] hold the system pulse length code. Reads return the stored fields at these positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register (combinational) |
| irq | output | 1 | Masked watchdog interrupt |
| cpu_rst | output | 1 | CPU reset pulse |
| sys_rst | output | 1 | System reset pulse |

## Verification
Read data follows the address in the same cycle. A register write becomes visible one cycle after its edge. A stage expiry shows on irq, cpu_rst or sys_rst in the sample that follows the P×T-th counting edge, and a pulse stays high for exactly its coded number of samples. The bench samples 1 ns after every rising edge. At each sample it compares all outputs with a behavioural model that steps once per edge. It also notes the cycle number of each output rise and fall, and checks the distances from the enabling write or the last restart against the counts given by the requirements.

// File: rtl/wdog_pkg.sv
// Shared constants, action encoding and helper functions for the staged watchdog.
// Assumes exactly four stages; the control-word layout depends on that count.
package wdog_pkg;
    localparam int NUM_STAGES = 4;
    localparam int STG_W      = $clog2(NUM_STAGES);
    localparam int ACT_W      = 2;
    localparam int LEN_W      = 3;

    typedef enum logic [ACT_W-1:0] {
        ACT_NONE    = 2'd0,
        ACT_IRQ     = 2'd1,
        ACT_CPU_RST = 2'd2,
        ACT_SYS_RST = 2'd3
    } wdog_act_e;

    localparam logic [31:0] WDOG_UNLOCK = 32'h50D8_3AA1;

    // register addresses
    localparam int unsigned REG_CTRL     = 0;
    localparam int unsigned REG_PRESC    = 1;
    localparam int unsigned REG_TMO_BASE = 2;
    localparam int unsigned REG_FEED     = 6;
    localparam int unsigned REG_KEY      = 7;
    localparam int unsigned REG_IRQ_EN   = 8;
    localparam int unsigned REG_IRQ_CLR  = 9;

    // control word field positions
    localparam int CTRL_RUN_BIT     = 0;
    localparam int CTRL_ACT_LSB     = 1;
    localparam int CTRL_CPU_LEN_LSB = 9;
    localparam int CTRL_SYS_LEN_LSB = 12;

    // Reset limit of each stage, in watchdog ticks.
    function automatic logic [31:0] stage_tmo_reset(input int idx);
        case (idx)
            0:       return 32'd26000000;
            1:       return 32'd134217727;
            default: return 32'd1048575;
        endcase
    endfunction

    // Pulse length in clock cycles: unit is the cycle count of the shortest step.
    function automatic int unsigned pulse_cycles(input logic [LEN_W-1:0] code,
                                                 input int unsigned unit);
        if (code < 3'd5) return unit * (32'(code) + 32'd1);
        else             return unit * (32'd8 << (32'(code) - 32'd5));
    endfunction
endpackage

// File: rtl/wdog_regs.sv
// Register file of the staged watchdog: key-guarded configuration, the
// unguarded key, restart and interrupt-clear strobes, the raw interrupt bit
// and a combinational read mux. Assumes DATA_W is 32 and TMO_W <= DATA_W.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int PRESC_W = 16,
    parameter int TMO_W   = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en_i,
    input  logic [ADDR_W-1:0]                   addr_i,
    input  logic [DATA_W-1:0]                   wdata_i,
    output logic [DATA_W-1:0]                   rdata_o,
    input  logic                                irq_set_i,
    output logic                                run_o,
    output logic [NUM_STAGES-1:0][ACT_W-1:0]    act_o,
    output logic [LEN_W-1:0]                    cpu_len_o,
    output logic [LEN_W-1:0]                    sys_len_o,
    output logic [PRESC_W-1:0]                  presc_o,
    output logic [NUM_STAGES-1:0][TMO_W-1:0]    tmo_o,
    output logic                                feed_o,
    output logic                                irq_o
);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_PRESC   = ADDR_W'(REG_PRESC);
    localparam logic [ADDR_W-1:0] A_FEED    = ADDR_W'(REG_FEED);
    localparam logic [ADDR_W-1:0] A_KEY     = ADDR_W'(REG_KEY);
    localparam logic [ADDR_W-1:0] A_IRQ_EN  = ADDR_W'(REG_IRQ_EN);
    localparam logic [ADDR_W-1:0] A_IRQ_CLR = ADDR_W'(REG_IRQ_CLR);

    logic [31:0]                       key_q;
    logic                              run_q;
    logic [NUM_STAGES-1:0][ACT_W-1:0]  act_q;
    logic [LEN_W-1:0]                  cpu_len_q;
    logic [LEN_W-1:0]                  sys_len_q;
    logic [PRESC_W-1:0]                presc_q;
    logic [TMO_W-1:0]                  tmo_q [NUM_STAGES];
    logic                              irq_en_q;
    logic                              raw_q;
    logic                              unlocked;
    logic                              cfg_we;
    logic                              irq_clr;
    logic [DATA_W-1:0]                 ctrl_word;

    assign unlocked = (key_q == WDOG_UNLOCK);
    assign cfg_we   = wr_en_i && unlocked;
    assign irq_clr  = wr_en_i && (addr_i == A_IRQ_CLR) && wdata_i[0];
    assign feed_o   = wr_en_i && (addr_i == A_FEED);

    // Key register: writable at all times.
    always_ff @(posedge clk) begin
        if (!rst_n)                              key_q <= WDOG_UNLOCK;
        else if (wr_en_i && addr_i == A_KEY)     key_q <= wdata_i[31:0];
    end

    // Control word: run bit, stage actions and pulse length codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            act_q     <= '0;
            cpu_len_q <= LEN_W'(1);
            sys_len_q <= LEN_W'(1);
        end else if (cfg_we && addr_i == A_CTRL) begin
            run_q <= wdata_i[CTRL_RUN_BIT];
            for (int s = 0; s < NUM_STAGES; s++) begin
                act_q[s] <= wdata_i[CTRL_ACT_LSB + ACT_W*s +: ACT_W];
            end
            cpu_len_q <= wdata_i[CTRL_CPU_LEN_LSB +: LEN_W];
            sys_len_q <= wdata_i[CTRL_SYS_LEN_LSB +: LEN_W];
        end
    end

    // Prescaler register.
    always_ff @(posedge clk) begin
        if (!rst_n)                           presc_q <= PRESC_W'(1);
        else if (cfg_we && addr_i == A_PRESC) presc_q <= wdata_i[PRESC_W-1:0];
    end

    // One limit register per stage.
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_tmo
        localparam logic [ADDR_W-1:0] A_TMO = ADDR_W'(REG_TMO_BASE + s);
        always_ff @(posedge clk) begin
            if (!rst_n)                         tmo_q[s] <= TMO_W'(stage_tmo_reset(s));
            else if (cfg_we && addr_i == A_TMO) tmo_q[s] <= wdata_i[TMO_W-1:0];
        end
        assign tmo_o[s] = tmo_q[s];
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                            irq_en_q <= 1'b0;
        else if (cfg_we && addr_i == A_IRQ_EN) irq_en_q <= wdata_i[0];
    end

    // Raw interrupt bit: a set wins over a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         raw_q <= 1'b0;
        else if (irq_set_i) raw_q <= 1'b1;
        else if (irq_clr)   raw_q <= 1'b0;
    end

    // Packs the control fields into their read-back positions.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_RUN_BIT] = run_q;
        for (int s = 0; s < NUM_STAGES; s++) begin
            ctrl_word[CTRL_ACT_LSB + ACT_W*s +: ACT_W] = act_q[s];
        end
        ctrl_word[CTRL_CPU_LEN_LSB +: LEN_W] = cpu_len_q;
        ctrl_word[CTRL_SYS_LEN_LSB +: LEN_W] = sys_len_q;
    end

    // Read mux of the addressed register.
    always_comb begin
        rdata_o = '0;
        if (addr_i == A_CTRL)         rdata_o = ctrl_word;
        else if (addr_i == A_PRESC)   rdata_o = DATA_W'(presc_q);
        else if (addr_i == A_KEY)     rdata_o = key_q;
        else if (addr_i == A_IRQ_EN)  rdata_o = DATA_W'(irq_en_q);
        else if (addr_i == A_IRQ_CLR) rdata_o = DATA_W'(raw_q);
        for (int s = 0; s < NUM_STAGES; s++) begin
            if (addr_i == ADDR_W'(REG_TMO_BASE + s)) rdata_o = DATA_W'(tmo_q[s]);
        end
    end

    assign run_o     = run_q;
    assign act_o     = act_q;
    assign cpu_len_o = cpu_len_q;
    assign sys_len_o = sys_len_q;
    assign presc_o   = presc_q;
    assign irq_o     = raw_q & irq_en_q;

    assert_locked_presc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !unlocked && addr_i == A_PRESC) |=> $stable(presc_o));
    assert_locked_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !unlocked && addr_i == A_CTRL) |=> $stable(ctrl_word));
    assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set_i |=> (rdata_o[0] || addr_i != A_IRQ_CLR) && raw_q);
    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !irq_set_i) |=> !irq_o);
endmodule

// File: rtl/wdog_seq.sv
// Prescaler and stage sequencer: counts ticks in the current stage and, at the
// limit, emits that stage's action strobe and steps to the next stage.
// Assumes configuration inputs come straight from registers (stable per cycle).
module wdog_seq
    import wdog_pkg::*;
#(
    parameter int PRESC_W = 16,
    parameter int TMO_W   = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              run_i,
    input  logic                              feed_i,
    input  logic [PRESC_W-1:0]                presc_i,
    input  logic [NUM_STAGES-1:0][TMO_W-1:0]  tmo_i,
    input  logic [NUM_STAGES-1:0][ACT_W-1:0]  act_i,
    output logic                              irq_set_o,
    output logic                              cpu_load_o,
    output logic                              sys_load_o
);
    localparam logic [STG_W-1:0] LAST_STAGE = STG_W'(NUM_STAGES - 1);

    logic [PRESC_W-1:0] pcnt_q;
    logic [TMO_W-1:0]   scnt_q;
    logic [STG_W-1:0]   stage_q;
    logic [PRESC_W-1:0] presc_eff;
    logic [PRESC_W:0]   pcnt_inc;
    logic [TMO_W:0]     scnt_inc;
    logic               counting;
    logic               tick;
    logic               expire;
    logic [ACT_W-1:0]   cur_act;

    assign counting  = run_i && !feed_i;
    assign presc_eff = (presc_i == '0) ? PRESC_W'(1) : presc_i;
    assign pcnt_inc  = {1'b0, pcnt_q} + {{PRESC_W{1'b0}}, 1'b1};
    assign scnt_inc  = {1'b0, scnt_q} + {{TMO_W{1'b0}}, 1'b1};
    assign tick      = (pcnt_inc >= {1'b0, presc_eff});
    assign expire    = counting && tick && (scnt_inc >= {1'b0, tmo_i[stage_q]});
    assign cur_act   = act_i[stage_q];

    // Prescale counter: wraps every presc_eff counting cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)         pcnt_q <= '0;
        else if (!counting) pcnt_q <= '0;
        else if (tick)      pcnt_q <= '0;
        else                pcnt_q <= pcnt_inc[PRESC_W-1:0];
    end

    // Stage index and tick count within the stage.
    always_ff @(posedge clk) begin
        if (!rst_n || !counting) begin
            stage_q <= '0;
            scnt_q  <= '0;
        end else if (expire) begin
            stage_q <= (stage_q == LAST_STAGE) ? '0 : stage_q + STG_W'(1);
            scnt_q  <= '0;
        end else if (tick) begin
            scnt_q  <= scnt_inc[TMO_W-1:0];
        end
    end

    // Decodes the action of the expiring stage into one strobe.
    always_comb begin
        irq_set_o  = expire && (cur_act == ACT_IRQ);
        cpu_load_o = expire && (cur_act == ACT_CPU_RST);
        sys_load_o = expire && (cur_act == ACT_SYS_RST);
    end

    assert_idle_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (stage_q == '0 && scnt_q == '0 && pcnt_q == '0));
    assert_feed_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        feed_i |=> (stage_q == '0 && scnt_q == '0));
    assert_stage_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (stage_q == (($past(stage_q) == LAST_STAGE) ? '0 : $past(stage_q) + STG_W'(1))));
    assert_expire_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (scnt_q == '0 && pcnt_q == '0));
endmodule

// File: rtl/wdog_pulse.sv
// Reset pulse stretcher: a load strobe starts a pulse whose length comes from a
// 3-bit code; a load during a pulse restarts it. Assumes UNIT_CYC >= 1.
module wdog_pulse
    import wdog_pkg::*;
#(
    parameter int unsigned UNIT_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] code_i,
    output logic             pulse_o
);
    localparam int unsigned MAX_CYC = UNIT_CYC * 32;
    localparam int          CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    // Down-counter holding the remaining pulse cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= CNT_W'(pulse_cycles(code_i, UNIT_CYC));
        else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end

    assign pulse_o = (cnt_q != '0);

    assert_load_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> pulse_o);
    assert_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && pulse_o) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/wdog_stages.sv
// Top of the four-stage watchdog: register file, stage sequencer and the two
// reset pulse stretchers. Assumes a 32-bit register data path.
module wdog_stages
    import wdog_pkg::*;
#(
    parameter int          ADDR_W     = 4,
    parameter int          PRESC_W    = 16,
    parameter int          TMO_W      = 32,
    parameter int unsigned PULSE_UNIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq,
    output logic              cpu_rst,
    output logic              sys_rst
);
    localparam int DATA_W = 32;

    logic                              run;
    logic [NUM_STAGES-1:0][ACT_W-1:0]  act;
    logic [LEN_W-1:0]                  cpu_len;
    logic [LEN_W-1:0]                  sys_len;
    logic [PRESC_W-1:0]                presc;
    logic [NUM_STAGES-1:0][TMO_W-1:0]  tmo;
    logic                              feed;
    logic                              irq_set;
    logic                              cpu_load;
    logic                              sys_load;

    wdog_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PRESC_W(PRESC_W),
        .TMO_W  (TMO_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .irq_set_i(irq_set),
        .run_o    (run),
        .act_o    (act),
        .cpu_len_o(cpu_len),
        .sys_len_o(sys_len),
        .presc_o  (presc),
        .tmo_o    (tmo),
        .feed_o   (feed),
        .irq_o    (irq)
    );

    wdog_seq #(
        .PRESC_W(PRESC_W),
        .TMO_W  (TMO_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .feed_i    (feed),
        .presc_i   (presc),
        .tmo_i     (tmo),
        .act_i     (act),
        .irq_set_o (irq_set),
        .cpu_load_o(cpu_load),
        .sys_load_o(sys_load)
    );

    wdog_pulse #(.UNIT_CYC(PULSE_UNIT)) u_cpu_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cpu_load),
        .code_i (cpu_len),
        .pulse_o(cpu_rst)
    );

    wdog_pulse #(.UNIT_CYC(PULSE_UNIT)) u_sys_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sys_load),
        .code_i (sys_len),
        .pulse_o(sys_rst)
    );

    assert_single_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_set, cpu_load, sys_load}));
endmodule

// File: tb/wdog_stages_test.sv
// Bench for wdog_stages: behavioural model stepped each edge plus event timing checks.
module wdog_stages_test;
    localparam longint UNLOCK = 64'h50D83AA1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    wire  [31:0] rdata;
    wire         irq, cpu_rst, sys_rst;

    always #2 clk = ~clk;

    wdog_stages #(.ADDR_W(4), .PRESC_W(16), .TMO_W(32), .PULSE_UNIT(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .cpu_rst(cpu_rst), .sys_rst(sys_rst));

    int errors = 0;
    int checks = 0;
    longint cyc = 0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural model ----------------
    bit     m_run, m_irq_en, m_raw;
    int     m_act [4];
    int     m_cpu_len, m_sys_len, m_stage, m_cpu_cnt, m_sys_cnt;
    longint m_presc, m_key, m_pcnt, m_scnt;
    longint m_tmo [4];

    function automatic int len_of(input int code);
        case (code)
            0: return 8;   1: return 16;  2: return 24;  3: return 32;
            4: return 40;  5: return 64;  6: return 128; default: return 256;
        endcase
    endfunction

    function automatic longint m_read(input int a);
        longint v;
        case (a)
            0: begin
                v = longint'(m_run) | (longint'(m_cpu_len) << 9) | (longint'(m_sys_len) << 12);
                for (int s = 0; s < 4; s++) v = v | (longint'(m_act[s]) << (1 + 2*s));
                return v;
            end
            1: return m_presc;
            2, 3, 4, 5: return m_tmo[a-2];
            7: return m_key;
            8: return longint'(m_irq_en);
            9: return longint'(m_raw);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit f_irq, f_cpu, f_sys, do_clr;
        longint p;
        f_irq = 0; f_cpu = 0; f_sys = 0;
        if (!rst_n) begin
            m_run = 0; m_irq_en = 0; m_raw = 0;
            for (int s = 0; s < 4; s++) m_act[s] = 0;
            m_cpu_len = 1; m_sys_len = 1; m_presc = 1; m_key = UNLOCK;
            m_tmo[0] = 26000000; m_tmo[1] = 134217727; m_tmo[2] = 1048575; m_tmo[3] = 1048575;
            m_pcnt = 0; m_scnt = 0; m_stage = 0; m_cpu_cnt = 0; m_sys_cnt = 0;
        end else begin
            if (!m_run || (wr_en && addr == 4'd6)) begin
                m_pcnt = 0; m_scnt = 0; m_stage = 0;
            end else begin
                p = (m_presc == 0) ? 1 : m_presc;
                if (m_pcnt + 1 >= p) begin
                    m_pcnt = 0;
                    if (m_scnt + 1 >= m_tmo[m_stage]) begin
                        f_irq = (m_act[m_stage] == 1);
                        f_cpu = (m_act[m_stage] == 2);
                        f_sys = (m_act[m_stage] == 3);
                        m_scnt = 0;
                        m_stage = (m_stage + 1) % 4;
                    end else m_scnt++;
                end else m_pcnt++;
            end
            if (f_cpu) m_cpu_cnt = len_of(m_cpu_len); else if (m_cpu_cnt > 0) m_cpu_cnt--;
            if (f_sys) m_sys_cnt = len_of(m_sys_len); else if (m_sys_cnt > 0) m_sys_cnt--;
            do_clr = wr_en && addr == 4'd9 && wdata[0];
            if (f_irq) m_raw = 1; else if (do_clr) m_raw = 0;
            if (wr_en) begin
                if (addr == 4'd7) m_key = longint'(wdata);
                else if (m_key == UNLOCK) begin
                    case (addr)
                        4'd0: begin
                            m_run = wdata[0];
                            for (int s = 0; s < 4; s++) m_act[s] = int'(wdata[1+2*s +: 2]);
                            m_cpu_len = int'(wdata[11:9]);
                            m_sys_len = int'(wdata[14:12]);
                        end
                        4'd1: m_presc = longint'(wdata[15:0]);
                        4'd2, 4'd3, 4'd4, 4'd5: m_tmo[addr-2] = longint'(wdata);
                        4'd8: m_irq_en = wdata[0];
                        default: ;
                    endcase
                end
            end
        end
    end

    // ---------------- sampling, compare and event monitor ----------------
    longint t_irq, t_cpu_r, t_cpu_f, t_sys_r, t_sys_f;
    logic p_irq = 0, p_cpu = 0, p_sys = 0;

    task automatic arm();
        t_irq = -1; t_cpu_r = -1; t_cpu_f = -1; t_sys_r = -1; t_sys_f = -1;
    endtask

    always begin
        @(posedge clk); #1;
        cyc++;
        check("R9", "cycle irq", longint'(irq), longint'(m_raw & m_irq_en));
        check("R6", "cycle cpu_rst", longint'(cpu_rst), longint'(m_cpu_cnt != 0));
        check("R6", "cycle sys_rst", longint'(sys_rst), longint'(m_sys_cnt != 0));
        check("R10", "cycle rdata", longint'(rdata), m_read(int'(addr)));
        if (irq && !p_irq && t_irq < 0) t_irq = cyc;
        if (cpu_rst && !p_cpu && t_cpu_r < 0) t_cpu_r = cyc;
        if (!cpu_rst && p_cpu && t_cpu_r >= 0 && t_cpu_f < 0) t_cpu_f = cyc;
        if (sys_rst && !p_sys && t_sys_r < 0) t_sys_r = cyc;
        if (!sys_rst && p_sys && t_sys_r >= 0 && t_sys_f < 0) t_sys_f = cyc;
        p_irq = irq; p_cpu = cpu_rst; p_sys = sys_rst;
        if (cyc > 60000) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung, got %0d cycles expected under 60000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- drivers ----------------
    task automatic wr(input int a, input longint d);
        @(negedge clk); wr_en = 1'b1; addr = 4'(a); wdata = 32'(d);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output longint v);
        @(negedge clk); addr = 4'(a);
        @(posedge clk); #1; v = longint'(rdata);
    endtask

    task automatic rd_chk(input string req, input int a, input longint exp);
        longint v;
        rd(a, v);
        check(req, $sformatf("read addr %0d", a), v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    longint en_at;

    initial begin
        arm();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset values
        rd_chk("R1", 0, 64'h1200);
        rd_chk("R1", 1, 1);
        rd_chk("R1", 2, 26000000);
        rd_chk("R1", 3, 134217727);
        rd_chk("R1", 4, 1048575);
        rd_chk("R1", 5, 1048575);
        rd_chk("R1", 7, UNLOCK);
        rd_chk("R1", 8, 0);
        rd_chk("R1", 9, 0);
        check("R1", "outputs low", longint'({irq, cpu_rst, sys_rst}), 0);

        // R10: control field layout
        wr(0, 64'h21C2);
        rd_chk("R10", 0, 64'h21C2);
        wr(1, 1); wr(2, 5); wr(3, 3); wr(4, 4); wr(5, 2); wr(8, 1);

        // R2: locked configuration, key always writable
        wr(7, 64'h1234);
        wr(2, 99); wr(0, 64'h21C3); wr(8, 0);
        rd_chk("R2", 2, 5);
        rd_chk("R2", 0, 64'h21C2);
        rd_chk("R2", 8, 1);
        rd_chk("R2", 7, 64'h1234);
        wr(7, UNLOCK);

        // R3: not running means no activity
        idle(30);
        check("R3", "no output while stopped", longint'({irq, cpu_rst, sys_rst}), 0);

        // R5 R6: stages irq, off, cpu, sys with limits 5,3,4,2 and 8-cycle pulses
        wr(0, 64'h01C3); en_at = cyc; arm();
        idle(40);
        check("R4", "irq rise after 5 ticks", t_irq - en_at, 5);
        check("R5", "cpu rise after stages 0..2", t_cpu_r - en_at, 12);
        check("R6", "sys rise after stage 3", t_sys_r - en_at, 14);
        check("R7", "cpu pulse code 0 width", t_cpu_f - t_cpu_r, 8);
        check("R7", "sys pulse code 0 width", t_sys_f - t_sys_r, 8);
        wr(0, 64'h01C2); idle(30);

        // R9: clear and mask
        wr(9, 1);
        check("R9", "irq after clear", longint'(irq), 0);
        rd_chk("R9", 9, 0);
        wr(8, 0); wr(0, 64'h01C3); idle(10);
        check("R9", "masked irq stays low", longint'(irq), 0);
        rd_chk("R9", 9, 1);
        wr(0, 64'h01C2); idle(30); wr(9, 1); wr(8, 1);

        // R7: long codes (cpu 5 -> 64, sys 7 -> 256)
        wr(2, 300); wr(3, 3); wr(0, 64'h7A1C);
        wr(0, 64'h7A1D); en_at = cyc; arm();
        idle(570);
        check("R6", "cpu rise at stage 0 end", t_cpu_r - en_at, 300);
        check("R6", "sys rise at stage 1 end", t_sys_r - en_at, 303);
        check("R7", "cpu pulse code 5 width", t_cpu_f - t_cpu_r, 64);
        check("R7", "sys pulse code 7 width", t_sys_f - t_sys_r, 256);
        check("R6", "no irq without irq action", t_irq, -1);
        wr(0, 64'h7A1C); idle(10);

        // R4: prescaler 3 and prescaler 0
        wr(2, 5); wr(1, 3); wr(0, 2); wr(9, 1);
        wr(0, 3); en_at = cyc; arm();
        idle(30);
        check("R4", "irq rise with prescaler 3", t_irq - en_at, 15);
        wr(0, 2); wr(9, 1); wr(1, 0);
        wr(0, 3); en_at = cyc; arm();
        idle(15);
        check("R4", "prescaler 0 acts as 1", t_irq - en_at, 5);
        wr(0, 2); wr(9, 1); wr(1, 1);

        // R8: restarts keep the watchdog quiet, also while locked
        wr(0, 3); arm();
        repeat (10) wr(6, 0);
        wr(7, 0);
        repeat (10) wr(6, 64'hDEAD);
        check("R8", "no irq while fed", t_irq, -1);
        en_at = cyc;
        idle(12);
        check("R8", "irq 5 ticks after last restart", t_irq - en_at, 5);
        wr(7, UNLOCK);
        idle(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule